// File: doc/BRIEF.md
# Dual-FIFO Message Mailbox

This block passes short messages between an application processor and an I/O co-processor. It contains two independent queues, one for each direction. The outbound queue carries traffic from the application side to the I/O side, and the inbound queue carries traffic back. Each message is a 64-bit first word plus a 32-bit second word. Both processors reach the block through the same 64-bit register port and share one address map.

A sender first writes the first word to a staging register. It then writes the second word, and that second write enqueues both words as one entry. A receiver reads the head's first word, which leaves the queue unchanged, and then reads the second word, which dequeues the entry. The second-word read also returns, in its upper bits, the queue's pointers, its own occupancy and the occupancy of the opposite queue. Each queue has a status register that reports full and empty.

Top module: `msg_mailbox`

## Requirements
- R1: After reset both queues are empty. A status read returns 0x20000, and a read of either head register returns all zeros.
- R2: Writing the staging register (outbound 0x60, inbound 0x90) enqueues nothing. Occupancy and status do not change.
- R3: Writing the second-word register (outbound 0x68, inbound 0x98) enqueues one entry. The entry holds the most recent staged first word and bits 31:0 of the write data; bits 63:32 of that write are ignored. A staged value is kept and can be reused by later enqueues.
- R4: Reading the first-word register (outbound 0x70, inbound 0xA0) returns the head's 64-bit first word and does not dequeue. Reading the second-word register (outbound 0x78, inbound 0xA8) returns the head's second word in bits 31:0 and dequeues it. Entries leave in arrival order.
- R5: In each status register (outbound 0x50, inbound 0x80), bit 16 is set when the queue holds 16 entries and bit 17 is set when it holds none. All other bits read as zero.
- R6: An enqueue into a full queue is dropped. The stored entries, the pointers and the occupancy are left unchanged.
- R7: A dequeue from an empty queue returns zero in bits 31:0, and the first-word register also reads zero. The pointers do not move.
- R8: A second-word read reports the following fields, all sampled before the dequeue:
  - bits 56:52: this queue's occupancy (0 to 16);
  - bits 51:48: the opposite queue's occupancy, saturated at 15;
  - bits 47:44: the read pointer;
  - bits 43:40: the write pointer.
  Both pointers wrap modulo 16. Bits 63:57 and 39:32 read as zero.
- R9: The two queues are independent, so an access to one never changes the other. At most one access (read or write) is made per cycle. Unmapped addresses read as zero, and read data is zero when no read is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; a read of a second-word register dequeues at the clock edge |
| reg_addr | input | 8 | Byte address of the register |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Combinational read data for the current address |

## Verification
The assertions assume that read and write strobes are never high in the same cycle, because the port carries a single address. The bench therefore drives every access as one strobe held for one cycle, followed by an idle cycle. The queue-level properties assume that enqueue and dequeue requests never coincide. This follows from the one-access rule, since the two requests decode different addresses. Every sweep drives the queues past full and past empty, so the drop and empty-dequeue paths run while those assumptions still hold.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int DATA_W      = 64;
    localparam int W0_W        = 64;
    localparam int W1_W        = 32;
    localparam int ADDR_W      = 8;
    localparam int FULL_BIT    = 16;
    localparam int EMPTY_BIT   = 17;
    localparam int OCC_LSB     = 52;
    localparam int OCC_W       = 5;
    localparam int PEER_LSB    = 48;
    localparam int PEER_W      = 4;
    localparam int RDP_LSB     = 44;
    localparam int WRP_LSB     = 40;
    localparam int PTRF_W      = 4;
    localparam int OFS_STAGE   = 0;
    localparam int OFS_PUSH    = 8;
    localparam int OFS_PEEK    = 16;
    localparam int OFS_TAKE    = 24;

    typedef struct packed {
        logic [W0_W-1:0] w0;
        logic [W1_W-1:0] w1;
    } mbx_entry_t;

    function automatic logic [ADDR_W-1:0] status_addr(input int ch);
        return (ch == 0) ? 8'h50 : 8'h80;
    endfunction

    function automatic logic [ADDR_W-1:0] data_base(input int ch);
        return (ch == 0) ? 8'h60 : 8'h90;
    endfunction
endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo
    import mbx_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  mbx_entry_t       push_data,
    output mbx_entry_t       head,
    output logic             empty,
    output logic             full,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [CNT_W-1:0] count
);
    typedef struct {
        mbx_entry_t       mem [DEPTH];
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [CNT_W-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     do_push, do_pop;

    always_comb begin
        st_d    = st_q;
        do_push = push && (st_q.cnt != CNT_W'(DEPTH));
        do_pop  = pop && (st_q.cnt != '0);
        if (do_push) begin
            st_d.mem[st_q.wp] = push_data;
            st_d.wp = (st_q.wp == PTR_W'(DEPTH - 1)) ? '0 : st_q.wp + 1'b1;
        end
        if (do_pop) begin
            st_d.rp = (st_q.rp == PTR_W'(DEPTH - 1)) ? '0 : st_q.rp + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.wp  <= '0;
            st_q.rp  <= '0;
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head   = st_q.mem[st_q.rp];
    assign empty  = (st_q.cnt == '0);
    assign full   = (st_q.cnt == CNT_W'(DEPTH));
    assign wr_ptr = st_q.wp;
    assign rd_ptr = st_q.rp;
    assign count  = st_q.cnt;

    logic [PTR_W:0] ptr_gap;
    always_comb begin
        if (st_q.wp >= st_q.rp) ptr_gap = {1'b0, st_q.wp} - {1'b0, st_q.rp};
        else                    ptr_gap = {1'b0, st_q.wp} + (PTR_W+1)'(DEPTH) - {1'b0, st_q.rp};
    end

    assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(DEPTH));
    assert_ptr_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (CNT_W'(ptr_gap) == st_q.cnt) || (ptr_gap == '0 && st_q.cnt == CNT_W'(DEPTH)));
    assert_push_grows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !full) |=> (st_q.cnt == $past(st_q.cnt) + 1'b1));
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && full) |=> ($stable(st_q.wp) && $stable(st_q.cnt)));
    assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && empty) |=> ($stable(st_q.rp) && $stable(st_q.cnt)));
    assert_no_both_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pop));
endmodule

// File: rtl/mbx_channel.sv
module mbx_channel
    import mbx_pkg::*;
#(
    parameter int CH    = 0,
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_wr,
    input  logic              acc_rd,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic [CNT_W-1:0]  peer_cnt,
    output logic [CNT_W-1:0]  own_cnt,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [ADDR_W-1:0] A_STAT  = status_addr(CH);
    localparam logic [ADDR_W-1:0] A_STAGE = data_base(CH) + ADDR_W'(OFS_STAGE);
    localparam logic [ADDR_W-1:0] A_PUSH  = data_base(CH) + ADDR_W'(OFS_PUSH);
    localparam logic [ADDR_W-1:0] A_PEEK  = data_base(CH) + ADDR_W'(OFS_PEEK);
    localparam logic [ADDR_W-1:0] A_TAKE  = data_base(CH) + ADDR_W'(OFS_TAKE);
    localparam int PEER_MAX = (1 << PEER_W) - 1;

    typedef struct packed {
        logic [W0_W-1:0] stage;
    } chan_st_t;

    chan_st_t         st_d, st_q;
    logic             push, pop, empty, full;
    mbx_entry_t       push_data, head;
    logic [PTR_W-1:0] wp, rp;
    logic [PEER_W-1:0] peer_f;

    always_comb begin
        st_d = st_q;
        if (acc_wr && acc_addr == A_STAGE) st_d.stage = acc_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign push      = acc_wr && (acc_addr == A_PUSH);
    assign pop       = acc_rd && (acc_addr == A_TAKE);
    assign push_data = '{w0: st_q.stage, w1: acc_wdata[W1_W-1:0]};

    mbx_fifo #(.DEPTH(DEPTH)) fifo_i (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
        .push_data(push_data), .head(head), .empty(empty), .full(full),
        .wr_ptr(wp), .rd_ptr(rp), .count(own_cnt)
    );

    assign peer_f = (peer_cnt > CNT_W'(PEER_MAX)) ? PEER_W'(PEER_MAX) : PEER_W'(peer_cnt);

    always_comb begin
        rdata = '0;
        if (acc_addr == A_STAT) begin
            rdata[FULL_BIT]  = full;
            rdata[EMPTY_BIT] = empty;
        end else if (acc_addr == A_PEEK) begin
            rdata = empty ? '0 : head.w0;
        end else if (acc_addr == A_TAKE) begin
            rdata[W1_W-1:0]                = empty ? '0 : head.w1;
            rdata[OCC_LSB +: OCC_W]        = OCC_W'(own_cnt);
            rdata[PEER_LSB +: PEER_W]      = peer_f;
            rdata[RDP_LSB +: PTRF_W]       = PTRF_W'(rp);
            rdata[WRP_LSB +: PTRF_W]       = PTRF_W'(wp);
        end
    end

    assert_stage_no_push_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && acc_addr == A_STAGE) |=> $stable(own_cnt));
    assert_peek_no_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd && acc_addr == A_PEEK) |=> ($stable(rp) && $stable(own_cnt)));
endmodule

// File: rtl/msg_mailbox.sv
module msg_mailbox
    import mbx_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata
);
    localparam int NCH = 2;

    logic [CNT_W-1:0]  occ     [NCH];
    logic [DATA_W-1:0] rd_each [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        mbx_channel #(.CH(g), .DEPTH(DEPTH)) chan_i (
            .clk(clk), .rst_n(rst_n),
            .acc_wr(reg_wr), .acc_rd(reg_rd),
            .acc_addr(reg_addr), .acc_wdata(reg_wdata),
            .peer_cnt(occ[NCH-1-g]), .own_cnt(occ[g]),
            .rdata(rd_each[g])
        );
    end

    assign reg_rdata = reg_rd ? (rd_each[0] | rd_each[1]) : '0;

    assert_one_access_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_rd));
    assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |-> (reg_rdata == '0));
endmodule

// File: tb/msg_mailbox_tb.sv
`timescale 1ns/1ps
module msg_mailbox_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;

    int          n_tests = 0;
    int          n_fail  = 0;
    logic [63:0] rd_val;

    logic [63:0] m0 [2][16];
    logic [31:0] m1 [2][16];
    logic [63:0] lat [2];
    int          wp [2], rp [2], cnt [2];

    always #2.5 clk = ~clk;

    msg_mailbox dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    function automatic logic [7:0] a_stat(input int ch);
        return (ch == 0) ? 8'h50 : 8'h80;
    endfunction
    function automatic logic [7:0] a_base(input int ch);
        return (ch == 0) ? 8'h60 : 8'h90;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [63:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 rd_val = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    function automatic logic [63:0] exp_stat(input int ch);
        logic [63:0] v = '0;
        v[16] = (cnt[ch] == 16);
        v[17] = (cnt[ch] == 0);
        return v;
    endfunction

    function automatic logic [63:0] exp_take(input int ch);
        logic [63:0] v = '0;
        int pc = (cnt[1-ch] > 15) ? 15 : cnt[1-ch];
        if (cnt[ch] != 0) v[31:0] = m1[ch][rp[ch]];
        v[56:52] = 5'(cnt[ch]);
        v[51:48] = 4'(pc);
        v[47:44] = 4'(rp[ch]);
        v[43:40] = 4'(wp[ch]);
        return v;
    endfunction

    task automatic stage(input int ch, input logic [63:0] w0);
        bus_wr(a_base(ch), w0);
        lat[ch] = w0;
        bus_rd(a_stat(ch));
        check("R2 stage write leaves status", rd_val, exp_stat(ch));
    endtask

    task automatic push2(input int ch, input logic [63:0] wd);
        bus_wr(a_base(ch) + 8'h08, wd);
        if (cnt[ch] < 16) begin
            m0[ch][wp[ch]] = lat[ch];
            m1[ch][wp[ch]] = wd[31:0];
            wp[ch] = (wp[ch] + 1) % 16;
            cnt[ch]++;
        end
        bus_rd(a_stat(ch));
        check((cnt[ch] == 16) ? "R5 R6 status after enqueue" : "R3 R5 status after enqueue",
              rd_val, exp_stat(ch));
        bus_rd(a_stat(1-ch));
        check("R9 opposite queue untouched", rd_val, exp_stat(1-ch));
    endtask

    task automatic take(input int ch);
        bus_rd(a_base(ch) + 8'h10);
        check((cnt[ch] == 0) ? "R7 peek empty" : "R4 peek head",
              rd_val, (cnt[ch] == 0) ? 64'h0 : m0[ch][rp[ch]]);
        bus_rd(a_base(ch) + 8'h18);
        check((cnt[ch] == 0) ? "R7 take empty" : "R4 R8 take head",
              rd_val, exp_take(ch));
        if (cnt[ch] > 0) begin
            rp[ch] = (rp[ch] + 1) % 16;
            cnt[ch]--;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R1..all actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int c = 0; c < 2; c++) begin
            lat[c] = '0; wp[c] = 0; rp[c] = 0; cnt[c] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        for (int c = 0; c < 2; c++) begin
            bus_rd(a_stat(c));
            check("R1 R5 reset status", rd_val, 64'h2_0000);
            bus_rd(a_base(c) + 8'h18);
            check("R1 reset take word", rd_val, 64'h0);
            bus_rd(a_base(c) + 8'h10);
            check("R1 reset peek word", rd_val, 64'h0);
        end
        bus_rd(8'h00);
        check("R9 unmapped address", rd_val, 64'h0);

        stage(0, 64'h1234_5678_9ABC_DEF0);

        for (int i = 0; i < 5; i++) begin
            stage(1, {32'h1100_0000 + 32'(i), 32'hBEEF_0000 + 32'(i)});
            push2(1, {32'hDEAD_DEAD, 32'h5000 + 32'(i)});
        end
        for (int i = 0; i < 16; i++) begin
            if (i % 3 != 0) stage(0, {32'hA000_0000 + 32'(i), 32'hC0DE_0000 + 32'(i * 9)});
            push2(0, {32'hFFFF_FFFF, 32'(i * 7 + 1)});
        end
        take(1);
        stage(0, 64'hFACE_FACE_FACE_FACE);
        push2(0, {32'h0, 32'h7777_7777});
        for (int i = 0; i < 17; i++) take(0);
        take(1);

        for (int c = 0; c < 2; c++) begin
            for (int it = 0; it < 40; it++) begin
                stage(c, {32'(c * 1000 + it), 32'h5A5A_0000 ^ 32'(it)});
                push2(c, {32'(it), 32'(it * 3 + c)});
                push2(c, {32'hF0F0_F0F0, 32'(it * 5 + 2)});
                push2(c, {32'h0, 32'hAB00 + 32'(it)});
                take(c);
                take(c);
            end
            while (cnt[c] > 0) take(c);
            take(c);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule